// File: doc/BRIEF.md
# Logarithmic-Format Multiply, Divide and Square-Root Unit

This unit works on real numbers held in a logarithmic format. Each word carries a two-bit class field, a sign bit, and the base-2 logarithm of the magnitude. The logarithm is a two's-complement fixed-point value with `WE` integer bits and `WF` fraction bits, so a word is `WE+WF+3` bits wide. The word stands for (-1)^sign × 2^log. In this format a product is an exact sum of logarithms and a quotient is an exact difference. A square root is an arithmetic right shift of the logarithm by one place. No rounding takes place except for the fraction bit that the square root drops.

Each clock, a datapath presents two operands and a two-bit opcode. The result appears on a registered output on the next clock edge, so the unit accepts a new operation every cycle. Zero, infinity and NaN are carried in the class field, using the same codes as the companion floating-point format. A sum or difference that leaves the logarithm range becomes infinity if it is too large and zero if it is too small.

Top module: `lns_muldiv_sqrt`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls if no operation has been clocked, `res_o` is all zeros (positive zero).
- R2: `res_o` is a register. The operation presented on the inputs at one rising edge shows on `res_o` after that edge and not before. One result is produced per cycle.
- R3: Word layout is {class[1:0], sign, log[WE+WF-1:0]}, with class 00 = zero, 01 = normal, 10 = infinity, 11 = NaN. Opcode 00 (multiply) of two normals gives a normal result whose log is the exact sum of the two logs and whose sign is the XOR of the two signs, when the sum fits the log range.
- R4: Opcode 01 (divide) of two normals gives a normal result whose log is the exact value a.log − b.log and whose sign is the XOR of the signs, when the difference fits.
- R5: If a multiply or divide of two normals yields a log above the largest representable value, the result is infinity (class 10) with the XOR sign.
- R6: If that log is below the smallest representable value, the result is zero (class 00) with the XOR sign.
- R7: Opcode 10 (square root) of a positive normal gives a positive normal whose log is the operand log shifted right by one with sign fill. The shift rounds toward minus infinity; for example, a log of −3 LSBs gives −2 LSBs. Operand b has no effect on this result.
- R8: Square root of zero gives zero with the operand's sign. Square root of +infinity gives +infinity. Square root of a negative normal or of −infinity gives NaN.
- R9: For multiply, a NaN operand gives NaN, and zero times infinity (in either order) gives NaN. Otherwise an infinite operand gives infinity and a zero operand gives zero, each with the XOR sign.
- R10: For divide, a NaN operand, 0/0 or inf/inf gives NaN. Otherwise a zero divisor or an infinite dividend gives infinity, and an infinite divisor or a zero dividend gives zero, each with the XOR sign.
- R11: Every NaN result is the word {11, 0, all-zero log}. Every zero or infinity result has an all-zero log field. Opcode 11 always gives NaN.
- R12: The log field of an operand whose class is not normal has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Opcode: 00 multiply, 01 divide, 10 square root, 11 reserved |
| a_i | input | WE+WF+3 | Operand a (dividend, or square-root operand) |
| b_i | input | WE+WF+3 | Operand b (divisor) |
| res_o | output | WE+WF+3 | Registered result word |

## Verification
The bench sweeps every pair of 8-bit words for multiply and divide, and every word for square root and the reserved opcode. This covers the range edges where a sum or difference spills one step beyond the log limits. A unit that dropped the extra sign bit would wrap there and return a normal result of the wrong magnitude instead of infinity or zero. The class crossings are the second target. Zero times infinity, 0/0 and inf/inf must give NaN, and a unit that chose the wrong order of precedence would give zero or infinity for them. The square root of odd negative logs shows whether the shift rounds toward minus infinity, since a logical shift or one that rounds toward zero gives a different log. Negative operands show whether square root maps them to NaN. Directed checks with stale log bits in zero operands show that a unit which leaked those bits into its output would fail.

// File: rtl/lns_pkg.sv
package lns_pkg;
  typedef enum logic [1:0] {
    EXC_ZERO = 2'b00,
    EXC_NORM = 2'b01,
    EXC_INF  = 2'b10,
    EXC_NAN  = 2'b11
  } exc_t;

  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_DIV  = 2'b01,
    OP_SQRT = 2'b10,
    OP_RSVD = 2'b11
  } op_t;
endpackage

// File: rtl/lns_unpack.sv
module lns_unpack
  import lns_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic [LW+2:0] word_i,
  output exc_t          exc_o,
  output logic          sgn_o,
  output logic [LW-1:0] log_o
);
  assign exc_o = exc_t'(word_i[LW+2:LW+1]);
  assign sgn_o = word_i[LW];
  assign log_o = word_i[LW-1:0];
endmodule

// File: rtl/lns_log_arith.sv
module lns_log_arith
  import lns_pkg::*;
#(
  parameter int LW = 5
) (
  input  op_t           op_i,
  input  logic [LW-1:0] la_i,
  input  logic [LW-1:0] lb_i,
  output logic [LW-1:0] lr_o,
  output logic          above_o,
  output logic          below_o
);
  // One guard bit: a sum or difference of two LW-bit values fits in LW+1.
  logic signed [LW:0] ext_a, ext_b, wide;

  always_comb begin
    ext_a = {la_i[LW-1], la_i};
    ext_b = {lb_i[LW-1], lb_i};
    unique case (op_i)
      OP_MUL:  wide = ext_a + ext_b;
      OP_DIV:  wide = ext_a - ext_b;
      default: wide = ext_a >>> 1;
    endcase
  end

  assign lr_o    = wide[LW-1:0];
  assign above_o = ~wide[LW] &  wide[LW-1];
  assign below_o =  wide[LW] & ~wide[LW-1];
endmodule

// File: rtl/lns_exc_resolve.sv
module lns_exc_resolve
  import lns_pkg::*;
(
  input  op_t  op_i,
  input  exc_t ea_i,
  input  exc_t eb_i,
  input  logic sa_i,
  input  logic sb_i,
  input  logic above_i,
  input  logic below_i,
  output exc_t er_o,
  output logic sr_o,
  output logic keep_log_o
);
  logic sx;

  always_comb begin
    sx         = sa_i ^ sb_i;
    er_o       = EXC_NAN;
    sr_o       = 1'b0;
    keep_log_o = 1'b0;
    unique case (op_i)
      OP_MUL: begin
        if (ea_i == EXC_NAN || eb_i == EXC_NAN) begin
          er_o = EXC_NAN;
        end else if ((ea_i == EXC_ZERO && eb_i == EXC_INF) ||
                     (ea_i == EXC_INF && eb_i == EXC_ZERO)) begin
          er_o = EXC_NAN;
        end else if (ea_i == EXC_INF || eb_i == EXC_INF) begin
          er_o = EXC_INF;  sr_o = sx;
        end else if (ea_i == EXC_ZERO || eb_i == EXC_ZERO) begin
          er_o = EXC_ZERO; sr_o = sx;
        end else if (above_i) begin
          er_o = EXC_INF;  sr_o = sx;
        end else if (below_i) begin
          er_o = EXC_ZERO; sr_o = sx;
        end else begin
          er_o = EXC_NORM; sr_o = sx; keep_log_o = 1'b1;
        end
      end
      OP_DIV: begin
        if (ea_i == EXC_NAN || eb_i == EXC_NAN) begin
          er_o = EXC_NAN;
        end else if ((ea_i == EXC_ZERO && eb_i == EXC_ZERO) ||
                     (ea_i == EXC_INF && eb_i == EXC_INF)) begin
          er_o = EXC_NAN;
        end else if (eb_i == EXC_ZERO || ea_i == EXC_INF) begin
          er_o = EXC_INF;  sr_o = sx;
        end else if (eb_i == EXC_INF || ea_i == EXC_ZERO) begin
          er_o = EXC_ZERO; sr_o = sx;
        end else if (above_i) begin
          er_o = EXC_INF;  sr_o = sx;
        end else if (below_i) begin
          er_o = EXC_ZERO; sr_o = sx;
        end else begin
          er_o = EXC_NORM; sr_o = sx; keep_log_o = 1'b1;
        end
      end
      OP_SQRT: begin
        if (ea_i == EXC_NAN) begin
          er_o = EXC_NAN;
        end else if (ea_i == EXC_ZERO) begin
          er_o = EXC_ZERO; sr_o = sa_i;
        end else if (sa_i) begin
          er_o = EXC_NAN;
        end else if (ea_i == EXC_INF) begin
          er_o = EXC_INF;
        end else begin
          er_o = EXC_NORM; keep_log_o = 1'b1;
        end
      end
      default: er_o = EXC_NAN;
    endcase
  end
endmodule

// File: rtl/lns_muldiv_sqrt.sv
module lns_muldiv_sqrt
  import lns_pkg::*;
#(
  parameter int WE = 3,
  parameter int WF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_i,
  input  logic [WE+WF+2:0]  a_i,
  input  logic [WE+WF+2:0]  b_i,
  output logic [WE+WF+2:0]  res_o
);
  localparam int LW = WE + WF;
  localparam int W  = LW + 3;
  localparam int NOPND = 2;

  op_t           op;
  logic [W-1:0]  opnd [NOPND];
  exc_t          ex   [NOPND];
  logic          sg   [NOPND];
  logic [LW-1:0] lg   [NOPND];

  assign op      = op_t'(op_i);
  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar i = 0; i < NOPND; i++) begin : g_unpack
    lns_unpack #(.LW(LW)) u_unpack (
      .word_i (opnd[i]),
      .exc_o  (ex[i]),
      .sgn_o  (sg[i]),
      .log_o  (lg[i])
    );
  end

  logic [LW-1:0] lr;
  logic          above, below;

  lns_log_arith #(.LW(LW)) u_arith (
    .op_i    (op),
    .la_i    (lg[0]),
    .lb_i    (lg[1]),
    .lr_o    (lr),
    .above_o (above),
    .below_o (below)
  );

  exc_t er;
  logic sr, keep_log;

  lns_exc_resolve u_resolve (
    .op_i       (op),
    .ea_i       (ex[0]),
    .eb_i       (ex[1]),
    .sa_i       (sg[0]),
    .sb_i       (sg[1]),
    .above_i    (above),
    .below_i    (below),
    .er_o       (er),
    .sr_o       (sr),
    .keep_log_o (keep_log)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
    end else begin
      res_o <= {er, sr, (keep_log ? lr : {LW{1'b0}})};
    end
  end
endmodule

// File: rtl/lns_muldiv_sqrt_chk.sv
module lns_muldiv_sqrt_chk #(
  parameter int WE = 3,
  parameter int WF = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       op_i,
  input logic [WE+WF+2:0] a_i,
  input logic [WE+WF+2:0] b_i,
  input logic [WE+WF+2:0] res_o
);
  localparam int LW = WE + WF;

  // R1: reset forces positive zero
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> res_o == '0);

  // R11: NaN results have a clean sign and log field
  a_r11_nan_clean: assert property (@(posedge clk) disable iff (rst)
    (res_o[LW+2:LW+1] == 2'b11) |-> (res_o[LW:0] == '0));

  // R9: a NaN operand to multiply yields NaN
  a_r9_mul_nan_in: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'b00 && a_i[LW+2:LW+1] == 2'b11) |=> res_o[LW+2:LW+1] == 2'b11);

  // R10: a normal dividend over a zero divisor yields infinity
  a_r10_div_by_zero: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'b01 && a_i[LW+2:LW+1] == 2'b01 && b_i[LW+2:LW+1] == 2'b00)
    |=> res_o[LW+2:LW+1] == 2'b10);

  // R7: root of a positive normal stays positive and normal
  a_r7_sqrt_pos: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'b10 && a_i[LW+2:LW+1] == 2'b01 && !a_i[LW])
    |=> (res_o[LW+2:LW+1] == 2'b01 && !res_o[LW]));

  // R11: reserved opcode gives NaN
  a_r11_rsvd_nan: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'b11) |=> res_o[LW+2:LW+1] == 2'b11);
endmodule

bind lns_muldiv_sqrt lns_muldiv_sqrt_chk #(.WE(WE), .WF(WF)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .op_i  (op_i),
  .a_i   (a_i),
  .b_i   (b_i),
  .res_o (res_o)
);

// File: tb/sim_lns_muldiv_sqrt.sv
`timescale 1ns/1ps
module sim_lns_muldiv_sqrt;
  localparam int WE = 3;
  localparam int WF = 2;
  localparam int LW = WE + WF;
  localparam int W  = LW + 3;
  localparam int MAXL = (1 << (LW - 1)) - 1;
  localparam int MINL = -(1 << (LW - 1));

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   op_i = 2'b00;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] res_o;

  int  n_chk = 0, n_bad = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  lns_muldiv_sqrt #(.WE(WE), .WF(WF)) u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(res_o));

  function automatic int to_int(input logic [LW-1:0] v);
    return v[LW-1] ? int'(v) - (1 << LW) : int'(v);
  endfunction

  function automatic logic [W-1:0] mk(input logic [1:0] c, input logic s, input int l);
    logic [LW-1:0] t;
    t = LW'(l);
    return {c, s, t};
  endfunction

  // Class codes: 00 zero, 01 normal, 10 inf, 11 NaN
  function automatic logic [W-1:0] model(input logic [1:0] op,
      input logic [W-1:0] a, input logic [W-1:0] b, output string tag);
    logic [1:0] ca, cb;
    logic sa, sb, sx;
    int la, lb, r;
    logic [W-1:0] nan_w;
    ca = a[W-1:W-2]; cb = b[W-1:W-2];
    sa = a[LW]; sb = b[LW]; sx = sa ^ sb;
    la = to_int(a[LW-1:0]); lb = to_int(b[LW-1:0]);
    nan_w = mk(2'b11, 1'b0, 0);
    if (op == 2'b11) begin tag = "R11"; return nan_w; end
    if (op == 2'b10) begin
      if (ca == 2'b11) begin tag = "R8"; return nan_w; end
      if (ca == 2'b00) begin tag = "R8"; return mk(2'b00, sa, 0); end
      if (sa) begin tag = "R8"; return nan_w; end
      if (ca == 2'b10) begin tag = "R8"; return mk(2'b10, 1'b0, 0); end
      r = (la >= 0) ? la / 2 : -((1 - la) / 2);
      tag = "R7"; return mk(2'b01, 1'b0, r);
    end
    if (op == 2'b00) begin
      tag = "R9";
      if (ca == 2'b11 || cb == 2'b11) return nan_w;
      if ((ca == 2'b00 && cb == 2'b10) || (ca == 2'b10 && cb == 2'b00)) return nan_w;
      if (ca == 2'b10 || cb == 2'b10) return mk(2'b10, sx, 0);
      if (ca == 2'b00 || cb == 2'b00) return mk(2'b00, sx, 0);
      r = la + lb; tag = "R3";
    end else begin
      tag = "R10";
      if (ca == 2'b11 || cb == 2'b11) return nan_w;
      if ((ca == 2'b00 && cb == 2'b00) || (ca == 2'b10 && cb == 2'b10)) return nan_w;
      if (cb == 2'b00 || ca == 2'b10) return mk(2'b10, sx, 0);
      if (cb == 2'b10 || ca == 2'b00) return mk(2'b00, sx, 0);
      r = la - lb; tag = "R4";
    end
    if (r > MAXL) begin tag = "R5"; return mk(2'b10, sx, 0); end
    if (r < MINL) begin tag = "R6"; return mk(2'b00, sx, 0); end
    return mk(2'b01, sx, r);
  endfunction

  task automatic check(input logic [W-1:0] exp_v, input string tag);
    n_chk++;
    if (res_o !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
               tag, op_i, a_i, b_i, res_o, exp_v);
    end
  endtask

  logic [W-1:0] exp_q;
  string        tag_q;
  bit           pend = 0;

  // Called at a falling edge: checks the previous op, then applies a new one.
  task automatic step(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    string t;
    if (pend) check(exp_q, tag_q);
    op_i = op; a_i = a; b_i = b;
    exp_q = model(op, a, b, t);
    tag_q = t;
    pend = 1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: reset holds zero even with live inputs
    op_i = 2'b00; a_i = mk(2'b01, 1'b1, 3); b_i = mk(2'b01, 1'b0, 2);
    repeat (3) @(negedge clk);
    check('0, "R1");
    rst = 1'b0;
    // R2: new inputs do not reach the output before the edge
    op_i = 2'b10; a_i = mk(2'b01, 1'b0, 6);
    #1;
    check('0, "R2");
    @(negedge clk);
    check(mk(2'b01, 1'b0, 3), "R2");
    // R12: stale log bits in a zero / infinity operand are ignored
    step(2'b00, mk(2'b00, 1'b0, 7), mk(2'b01, 1'b1, 5));
    step(2'b01, mk(2'b01, 1'b0, 9), mk(2'b10, 1'b0, 13));
    step(2'b10, mk(2'b00, 1'b1, 11), '0);
    if (pend) check(exp_q, "R12");
    pend = 0;
    // R7: odd negative log rounds toward minus infinity
    step(2'b10, mk(2'b01, 1'b0, -3), '0);
    check(mk(2'b01, 1'b0, -2), "R7");
    pend = 0;
    // R5 and R6 range edges, directed
    step(2'b00, mk(2'b01, 1'b0, MAXL), mk(2'b01, 1'b1, 1));
    check(mk(2'b10, 1'b1, 0), "R5");
    pend = 0;
    step(2'b01, mk(2'b01, 1'b1, MINL), mk(2'b01, 1'b1, 1));
    check(mk(2'b00, 1'b0, 0), "R6");
    pend = 0;
    // Exhaustive multiply and divide
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          step(2'(op), W'(a), W'(b));
    // Square root and reserved opcode over all operands
    for (int a = 0; a < (1 << W); a++) step(2'b10, W'(a), W'(a * 37));
    for (int a = 0; a < (1 << W); a++) step(2'b11, W'(a), W'(255 - a));
    if (pend) check(exp_q, tag_q);
    finish_run();
  end
endmodule